// File: doc/BRIEF.md
# System Clock Source Switch

This block chooses which of three clock sources drives the system clock. Source 0 is an internal RC oscillator, source 1 is an external crystal oscillator and source 2 is a PLL. Software writes a two-bit request code. The block then moves the clock output to the requested source without a glitch. A separate two-bit status output reports which source is actually gating the output. The status changes only once a switch is complete, so it lags the request.

Each source has its own gate flop. The gate is enabled through two synchronizer stages clocked by that source, and it updates on that source's falling edge. The control state machine runs on an always-on control clock. It disables the old gate and waits for confirmation before it enables the new one.

Hardware overrides the request in two cases. The first is an exit from a low-power mode. The second is a crystal failure while the crystal feeds the clock, either directly or as the PLL reference. In both cases the request returns to the RC oscillator and the gates fed by the crystal are cleared at once. A crystal failure also pulses a flag toward the interrupt logic.

Top module: `sysclk_switch`

## Requirements
- R1: After reset, sel_req and sel_stat are 00, fail_flag is 0, and sys_clk follows the RC oscillator (source 0).
- R2: A write with req_we high and code 00 (RC), 01 (crystal) or 10 (PLL) appears on sel_req one control clock later. A write of 11 is ignored and sel_req keeps its value.
- R3: sel_stat uses the same encoding and never shows 11. Once it names a source, sys_clk equals that source's clock.
- R4: A switch starts only when src_ready of the target source is high. While it is low, sel_stat and sys_clk stay on the old source.
- R5: Break before make: at most one source gate is open at any time. The new gate is enabled only after the old gate is seen closed.
- R6: A pulse on lp_exit forces sel_req to 00 one cycle later, and sel_stat then reaches 00. fail_flag stays 0.
- R7: A pulse on xtal_fail while sel_stat is 01 forces sel_req to 00 and raises fail_flag for one cycle, both one cycle later. sel_stat then reaches 00.
- R8: A pulse on xtal_fail while sel_stat is 10 forces the same fallback when pll_ref_xtal is 1. It has no effect on sel_req, sel_stat or fail_flag when pll_ref_xtal is 0.
- R9: A request made while a switch is in progress (switching high) is stored, and it is served after the current switch finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 3 | Source clocks: bit 0 RC, bit 1 crystal, bit 2 PLL |
| src_ready | input | 3 | Per-source ready indication, same bit order |
| pll_ref_xtal | input | 1 | High when the PLL is referenced to the crystal |
| xtal_fail | input | 1 | Crystal monitor failure report |
| lp_exit | input | 1 | Pulse on exit from a low-power mode |
| req_we | input | 1 | Request write strobe |
| req_code | input | 2 | Requested source code |
| sys_clk | output | 1 | Glitch-free system clock |
| sel_req | output | 2 | Stored request |
| sel_stat | output | 2 | Source currently driving sys_clk |
| switching | output | 1 | High while a switch sequence runs |
| fail_flag | output | 1 | One-cycle pulse on a crystal failure fallback |

## Verification
Two results are due one control clock after the stimulus edge: sel_req after a write, and sel_req plus fail_flag after a fallback pulse. The bench samples both 3 ns after the next falling edge. sel_stat moves only after two hops across clock domains, so the bench polls it for up to 60 control cycles and compares it only after it settles. It also checks that it does not move while the target is not ready. The sys_clk check is taken at odd nanosecond offsets, where no source clock edge can fall, so the comparison with the selected source clock is free of races.

// File: rtl/sysclk_switch.sv
module sysclk_switch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src_clk,
  input  logic [2:0] src_ready,
  input  logic       pll_ref_xtal,
  input  logic       xtal_fail,
  input  logic       lp_exit,
  input  logic       req_we,
  input  logic [1:0] req_code,
  output logic       sys_clk,
  output logic [1:0] sel_req,
  output logic [1:0] sel_stat,
  output logic       switching,
  output logic       fail_flag
);

  typedef enum logic [1:0] {IDLE, DROP, RAISE} st_t;

  st_t        st;
  logic [1:0] tgt;
  logic [2:0] en_req, gate, ack_m, ack;
  logic       kill;

  wire xtal_used = (sel_stat == 2'd1) || (sel_stat == 2'd2 && pll_ref_xtal) ||
                   (st != IDLE && (tgt == 2'd1 || (tgt == 2'd2 && pll_ref_xtal)));
  wire xfail     = xtal_fail && xtal_used;
  wire force_irc = lp_exit || xfail;
  wire [2:0] tgt_oh = 3'b001 << tgt;

  for (genvar i = 0; i < 3; i++) begin : g_src
    localparam bit ON0 = (i == 0);
    localparam bit KILLABLE = (i != 0);
    logic s1, s2, g;
    wire clr = !rst_n || (kill && KILLABLE);
    always_ff @(posedge src_clk[i] or posedge clr)
      if (clr) {s1, s2} <= {ON0, ON0};
      else     {s1, s2} <= {en_req[i], s1};
    always_ff @(negedge src_clk[i] or posedge clr)
      if (clr) g <= ON0;
      else     g <= s2;
    assign gate[i] = g;
  end

  assign sys_clk   = |(src_clk & gate);
  assign switching = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {ack, ack_m} <= {3'b001, 3'b001};
    else        {ack, ack_m} <= {ack_m, gate};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; tgt <= 2'd0; sel_req <= 2'd0; sel_stat <= 2'd0;
      en_req <= 3'b001; kill <= 1'b0; fail_flag <= 1'b0;
    end else begin
      kill      <= force_irc;
      fail_flag <= xfail;
      if (force_irc) begin
        sel_req <= 2'd0;
        en_req  <= 3'b001;
        tgt     <= 2'd0;
        st      <= RAISE;
      end else begin
        if (req_we && req_code != 2'b11) sel_req <= req_code;
        case (st)
          IDLE:
            if (sel_req != sel_stat && src_ready[sel_req]) begin
              tgt    <= sel_req;
              en_req <= 3'b000;
              st     <= DROP;
            end
          DROP:
            if (ack == 3'b000) begin
              en_req <= tgt_oh;
              st     <= RAISE;
            end
          RAISE:
            if (ack == tgt_oh) begin
              sel_stat <= tgt;
              st       <= IDLE;
            end
          default: st <= IDLE;
        endcase
      end
    end
  end

  assert_req_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_req != 2'b11);
  assert_stat_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stat != 2'b11);
  assert_one_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gate));
  assert_stat_after_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_stat) |-> $past(ack) == (3'b001 << sel_stat));
  assert_force_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    force_irc |=> sel_req == 2'd0);
  assert_fail_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag |-> sel_req == 2'd0);

endmodule

// File: tb/sysclk_switch_test.sv
module sysclk_switch_test;
  logic clk = 0, rst_n = 0;
  logic ck0 = 0, ck1 = 0, ck2 = 0;
  logic [2:0] src_ready = 3'b111;
  logic pll_ref_xtal = 0, xtal_fail = 0, lp_exit = 0, req_we = 0;
  logic [1:0] req_code = 0;
  wire [2:0] src_clk = {ck2, ck1, ck0};
  logic sys_clk, switching, fail_flag;
  logic [1:0] sel_req, sel_stat;
  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;
  always #8  ck0 = ~ck0;
  always #12 ck1 = ~ck1;
  always #6  ck2 = ~ck2;

  sysclk_switch uut (.clk(clk), .rst_n(rst_n), .src_clk(src_clk), .src_ready(src_ready),
    .pll_ref_xtal(pll_ref_xtal), .xtal_fail(xtal_fail), .lp_exit(lp_exit),
    .req_we(req_we), .req_code(req_code), .sys_clk(sys_clk), .sel_req(sel_req),
    .sel_stat(sel_stat), .switching(switching), .fail_flag(fail_flag));

  // {code written, expected request, expected status}
  localparam logic [5:0] VEC [6] = '{
    {2'b01, 2'b01, 2'b01}, {2'b10, 2'b10, 2'b10}, {2'b11, 2'b10, 2'b10},
    {2'b00, 2'b00, 2'b00}, {2'b10, 2'b10, 2'b10}, {2'b01, 2'b01, 2'b01}};

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #3;
  endtask

  task automatic write_req(input logic [1:0] code);
    @(negedge clk); req_we = 1; req_code = code;
    @(negedge clk); req_we = 0; #3;
  endtask

  task automatic wait_stat(input logic [1:0] exp);
    for (int k = 0; k < 60 && !(sel_stat == exp && !switching); k++) tick();
  endtask

  task automatic check_follow(input logic [1:0] s, input string tag);
    int bad = 0;
    for (int k = 0; k < 8; k++) begin
      tick();
      if (sys_clk !== src_clk[s]) bad++;
    end
    check(bad == 0, tag, bad, 0);
  endtask

  initial begin
    #4000000;
    nbad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #35 rst_n = 1;
    tick();
    // R1 reset state
    check(sel_req == 0, "R1 sel_req", sel_req, 0);
    check(sel_stat == 0, "R1 sel_stat", sel_stat, 0);
    check(fail_flag == 0, "R1 fail_flag", fail_flag, 0);
    check_follow(2'd0, "R1 sys_clk on rc");

    // R2 R3 table
    foreach (VEC[i]) begin
      write_req(VEC[i][5:4]);
      check(sel_req == VEC[i][3:2], "R2 sel_req after write", sel_req, VEC[i][3:2]);
      wait_stat(VEC[i][1:0]);
      check(sel_stat == VEC[i][1:0], "R3 sel_stat settled", sel_stat, VEC[i][1:0]);
      check_follow(VEC[i][1:0], "R3 sys_clk follows status");
    end

    // R4 target not ready
    src_ready[2] = 0;
    write_req(2'b10);
    for (int k = 0; k < 30; k++) tick();
    check(sel_stat == 2'b01, "R4 stat held while not ready", sel_stat, 1);
    check_follow(2'd1, "R4 sys_clk held");
    src_ready[2] = 1;
    wait_stat(2'b10);
    check(sel_stat == 2'b10, "R4 stat after ready", sel_stat, 2);

    // R8 crystal fail with PLL not on crystal: no effect
    pll_ref_xtal = 0;
    @(negedge clk); xtal_fail = 1; @(negedge clk); xtal_fail = 0; #3;
    check(fail_flag == 0, "R8 no flag", fail_flag, 0);
    check(sel_req == 2'b10, "R8 req kept", sel_req, 2);
    for (int k = 0; k < 10; k++) tick();
    check(sel_stat == 2'b10, "R8 stat kept", sel_stat, 2);

    // R8 crystal fail with PLL on crystal: fallback
    pll_ref_xtal = 1;
    @(negedge clk); xtal_fail = 1; @(negedge clk); xtal_fail = 0; #3;
    check(fail_flag == 1, "R8 flag", fail_flag, 1);
    check(sel_req == 2'b00, "R8 req forced", sel_req, 0);
    tick();
    check(fail_flag == 0, "R8 flag one cycle", fail_flag, 0);
    wait_stat(2'b00);
    check(sel_stat == 2'b00, "R8 stat fallback", sel_stat, 0);
    check_follow(2'd0, "R8 sys_clk on rc");
    pll_ref_xtal = 0;

    // R7 crystal fail while crystal direct
    write_req(2'b01);
    wait_stat(2'b01);
    @(negedge clk); xtal_fail = 1; @(negedge clk); xtal_fail = 0; #3;
    check(fail_flag == 1, "R7 flag", fail_flag, 1);
    check(sel_req == 2'b00, "R7 req forced", sel_req, 0);
    wait_stat(2'b00);
    check(sel_stat == 2'b00, "R7 stat fallback", sel_stat, 0);
    check_follow(2'd0, "R7 sys_clk on rc");

    // R6 low-power exit
    write_req(2'b10);
    wait_stat(2'b10);
    @(negedge clk); lp_exit = 1; @(negedge clk); lp_exit = 0; #3;
    check(sel_req == 2'b00, "R6 req forced", sel_req, 0);
    check(fail_flag == 0, "R6 no flag", fail_flag, 0);
    wait_stat(2'b00);
    check(sel_stat == 2'b00, "R6 stat fallback", sel_stat, 0);

    // R9 request during a switch
    write_req(2'b01);
    tick();
    check(switching == 1, "R9 switch running", switching, 1);
    write_req(2'b10);
    check(sel_req == 2'b10, "R9 second req stored", sel_req, 2);
    for (int k = 0; k < 3 && sel_stat == 2'b00; k++) wait_stat(2'b10);
    wait_stat(2'b10);
    check(sel_stat == 2'b10, "R9 second req served", sel_stat, 2);
    check_follow(2'd2, "R9 sys_clk on pll");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule